// File: doc/BRIEF.md
# Memory Self-Test Pattern Engine

This block tests a RAM with 64-bit words. Each run covers the addresses from a start value up to an end value, and the end address itself is not tested. A run has three phases that always come in the same order. Phase one writes and reads back a fixed set of background words. Phase two checks that each address is unique by storing every address as the data at that address. Phase three steps a single set bit through each 32-bit half of the word, and each step is followed by its bitwise inverse. The engine drives a plain synchronous RAM port. That port has an address, write data, write strobe and read strobe, and read data returns after a fixed latency set by a parameter.

For every pattern, the engine first writes all words in the range in ascending order. It then reads them all back in the same order and compares each word to the pattern. At the first mismatch the run stops and fail is raised. The engine also holds the failing address, the data it expected and the data it read. A run is started with a one-cycle pulse. When the run ends, done rises and stays high until the next run begins. Two counters record how many runs passed and how many failed.

Top module: `mem_bist_engine`

## Requirements
- R1: A run accesses only words `a` with `start_addr <= a < end_addr`, latched at start, in ascending order in every sweep. If `start_addr >= end_addr`, the run passes with no RAM access at all.
- R2: Patterns 0..8 are the background words 0x0000000000000000, 0xFFFFFFFFFFFFFFFF, 0xAAAAAAAAAAAAAAAA, 0x5555555555555555, 0xCCCCCCCCCCCCCCCC, 0xF0F0F0F0F0F0F0F0, 0xFF00FF00FF00FF00, 0xFFFF0000FFFF0000 and 0xFFFFFFFF00000000, in that order. For each pattern, a full write sweep is followed by a full read sweep. Write and read strobes are never high in the same cycle.
- R3: Pattern 9 is the address test. It runs after all background patterns and before the walking phase, and each word holds its own address, zero-extended to 64 bits.
- R4: Patterns 10..73 are the walking phase. For k = 0..31, the word with bit k set in both 32-bit halves, (1<<k)*0x0000000100000001, comes first, and its bitwise complement comes right after it.
- R5: A read strobe high in cycle n is answered by `mem_rdata` in cycle n+RD_LAT, and the compare uses that word.
- R6: At the first mismatch the run ends with `fail` high. `fail_addr`, `fail_expected` and `fail_actual` hold the address, the pattern word and the word read, and no further RAM access follows.
- R7: `done` goes high when a run ends and stays high, with no RAM access, until the next accepted start. A start pulse during a run is ignored.
- R8: Each finished run increments exactly one of `pass_count` and `fail_count`.
- R9: After reset, `done`, `fail`, both strobes and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request, taken only when no run is active |
| start_addr | input | AW | First word address of the range |
| end_addr | input | AW | Exclusive end of the range |
| mem_addr | output | AW | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 64 | RAM write data |
| mem_rdata | input | 64 | RAM read data, valid RD_LAT cycles after the read strobe |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Finished run found a mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_expected | output | 64 | Pattern word expected at that address |
| fail_actual | output | 64 | Word actually read there |
| pass_count | output | CW | Number of passing runs |
| fail_count | output | CW | Number of failing runs |

## Verification
A fault-free RAM model checks the full write and read order. The same model catches a wrong read latency, which would misalign the compares. A bit of one word stuck at one is caught by the very first background pattern, which shows that the background phase is wired and sees data faults. An aliasing decoder, where writes to one address also land on another, passes every background pattern and is caught only by the address test. That proves the address phase adds coverage and reports the aliased value. Empty and single-word ranges, plus a start pulse in the middle of a run, test the range edges and the rule that ignores starts while busy.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int DW        = 64;
  localparam int HALF_W    = DW / 2;
  localparam int NUM_FILL  = 9;
  localparam int NUM_PAT   = NUM_FILL + 1 + 2 * HALF_W;
  localparam int PW        = $clog2(NUM_PAT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_DRAIN,
    ST_DONE
  } mbist_state_e;
endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen
  import mbist_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [PW-1:0] idx,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic [PW-1:0]     k;
  logic [HALF_W-1:0] w;

  always_comb begin
    k = idx - PW'(NUM_FILL + 1);
    w = HALF_W'(1) << k[PW-1:1];
    case (idx)
      PW'(0):        data = '0;
      PW'(1):        data = '1;
      PW'(2):        data = {32{2'b10}};
      PW'(3):        data = {32{2'b01}};
      PW'(4):        data = {16{4'b1100}};
      PW'(5):        data = {8{8'hF0}};
      PW'(6):        data = {4{16'hFF00}};
      PW'(7):        data = {2{32'hFFFF0000}};
      PW'(8):        data = {32'hFFFFFFFF, 32'h0};
      PW'(NUM_FILL): data = DW'(addr);
      default:       data = k[0] ? ~{w, w} : {w, w};
    endcase
  end
endmodule

// File: rtl/mbist_rd_pipe.sv
module mbist_rd_pipe #(
  parameter int AW  = 10,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic          busy
);
  logic [LAT-1:0] vld;
  logic [AW-1:0]  adr [LAT];

  always_ff @(posedge clk) begin
    if (rst || flush) vld[0] <= 1'b0;
    else              vld[0] <= in_vld;
    adr[0] <= in_addr;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || flush) vld[i] <= 1'b0;
      else              vld[i] <= vld[i-1];
      adr[i] <= adr[i-1];
    end
  end

  assign out_vld  = vld[LAT-1];
  assign out_addr = adr[LAT-1];
  assign busy     = |vld;

  assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
    flush |=> !busy);
endmodule

// File: rtl/mem_bist_engine.sv
module mem_bist_engine
  import mbist_pkg::*;
#(
  parameter int AW     = 10,
  parameter int RD_LAT = 2,
  parameter int CW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [63:0]   fail_expected,
  output logic [63:0]   fail_actual,
  output logic [CW-1:0] pass_count,
  output logic [CW-1:0] fail_count
);
  localparam logic [PW-1:0] LAST_PAT = PW'(NUM_PAT - 1);

  mbist_state_e  state;
  logic [PW-1:0] pat;
  logic [AW-1:0] cur, lo_q, hi_q;
  logic [DW-1:0] wr_pat, exp_pat;
  logic [AW-1:0] cmp_addr;
  logic          cmp_vld, pipe_busy, start_ok, cmp_en, miscmp;

  assign start_ok = start && (state == ST_IDLE || state == ST_DONE);
  assign cmp_en   = cmp_vld && (state == ST_RD || state == ST_DRAIN);
  assign miscmp   = cmp_en && (mem_rdata != exp_pat);

  mbist_patgen #(.AW(AW)) u_wr_pat (.idx(pat), .addr(cur),      .data(wr_pat));
  mbist_patgen #(.AW(AW)) u_cmp_pat(.idx(pat), .addr(cmp_addr), .data(exp_pat));

  mbist_rd_pipe #(.AW(AW), .LAT(RD_LAT)) u_pipe (
    .clk(clk), .rst(rst), .flush(start_ok),
    .in_vld(mem_re), .in_addr(mem_addr),
    .out_vld(cmp_vld), .out_addr(cmp_addr), .busy(pipe_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pat           <= '0;
      cur           <= '0;
      lo_q          <= '0;
      hi_q          <= '0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      mem_we        <= 1'b0;
      mem_re        <= 1'b0;
      done          <= 1'b0;
      fail          <= 1'b0;
      fail_addr     <= '0;
      fail_expected <= '0;
      fail_actual   <= '0;
      pass_count    <= '0;
      fail_count    <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      if (start_ok) begin
        state         <= ST_WR;
        pat           <= '0;
        cur           <= start_addr;
        lo_q          <= start_addr;
        hi_q          <= end_addr;
        done          <= 1'b0;
        fail          <= 1'b0;
        fail_addr     <= '0;
        fail_expected <= '0;
        fail_actual   <= '0;
      end else if (miscmp) begin
        state         <= ST_DONE;
        done          <= 1'b1;
        fail          <= 1'b1;
        fail_addr     <= cmp_addr;
        fail_expected <= exp_pat;
        fail_actual   <= mem_rdata;
        fail_count    <= fail_count + 1'b1;
      end else begin
        case (state)
          ST_WR: begin
            if (cur < hi_q) begin
              mem_we    <= 1'b1;
              mem_addr  <= cur;
              mem_wdata <= wr_pat;
              cur       <= cur + 1'b1;
            end else begin
              cur   <= lo_q;
              state <= ST_RD;
            end
          end
          ST_RD: begin
            if (cur < hi_q) begin
              mem_re   <= 1'b1;
              mem_addr <= cur;
              cur      <= cur + 1'b1;
            end else begin
              state <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (!pipe_busy) begin
              if (pat == LAST_PAT) begin
                state      <= ST_DONE;
                done       <= 1'b1;
                pass_count <= pass_count + 1'b1;
              end else begin
                pat   <= pat + 1'b1;
                cur   <= lo_q;
                state <= ST_WR;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_addr_window_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> (mem_addr >= lo_q && mem_addr < hi_q));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !(mem_we || mem_re));

  assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  assert_one_counter_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ((pass_count != $past(pass_count)) != (fail_count != $past(fail_count))));
endmodule

// File: tb/sim_mem_bist_engine.sv
module sim_mem_bist_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int RD_LAT = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re;
  logic [63:0] mem_wdata, mem_rdata;
  logic done, fail;
  logic [AW-1:0] fail_addr;
  logic [63:0] fail_expected, fail_actual;
  logic [CW-1:0] pass_count, fail_count;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bist_engine #(.AW(AW), .RD_LAT(RD_LAT), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_expected(fail_expected), .fail_actual(fail_actual),
    .pass_count(pass_count), .fail_count(fail_count)
  );

  // behavioural RAM with optional faults
  logic [63:0] ram [0:(1<<AW)-1];
  logic [63:0] rdq [RD_LAT];
  logic stuck_en = 1'b0;
  logic [AW-1:0] stuck_addr = '0;
  logic [63:0] stuck_mask = '0, stuck_val = '0;
  logic alias_en = 1'b0;
  logic [AW-1:0] alias_lo = '0, alias_hi = '0;

  always @(posedge clk) begin
    logic [63:0] rd;
    rd = ram[mem_addr];
    if (stuck_en && mem_addr == stuck_addr) rd = (rd & ~stuck_mask) | (stuck_val & stuck_mask);
    for (int i = RD_LAT - 1; i > 0; i--) rdq[i] <= rdq[i-1];
    rdq[0] <= rd;
    if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
      if (alias_en && mem_addr == alias_hi) ram[alias_lo] <= mem_wdata;
    end
  end
  assign mem_rdata = rdq[RD_LAT-1];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference pattern, written from the requirement text
  function automatic logic [63:0] ref_pat(int p, int a);
    logic [63:0] bg [9];
    logic [63:0] w;
    bg[0] = 64'h0000000000000000; bg[1] = 64'hFFFFFFFFFFFFFFFF;
    bg[2] = 64'hAAAAAAAAAAAAAAAA; bg[3] = 64'h5555555555555555;
    bg[4] = 64'hCCCCCCCCCCCCCCCC; bg[5] = 64'hF0F0F0F0F0F0F0F0;
    bg[6] = 64'hFF00FF00FF00FF00; bg[7] = 64'hFFFF0000FFFF0000;
    bg[8] = 64'hFFFFFFFF00000000;
    if (p < 9) return bg[p];
    if (p == 9) return 64'(a);
    w = 64'h0000000100000001 << ((p - 10) / 2);
    return ((p - 10) % 2 == 1) ? ~w : w;
  endfunction

  bit           q_we   [$];
  int           q_addr [$];
  logic [63:0]  q_data [$];
  int           q_pat  [$];

  task automatic build_ops(int lo, int hi);
    q_we.delete(); q_addr.delete(); q_data.delete(); q_pat.delete();
    for (int p = 0; p < 74; p++) begin
      for (int a = lo; a < hi; a++) begin
        q_we.push_back(1'b1); q_addr.push_back(a); q_data.push_back(ref_pat(p, a)); q_pat.push_back(p);
      end
      for (int a = lo; a < hi; a++) begin
        q_we.push_back(1'b0); q_addr.push_back(a); q_data.push_back('0); q_pat.push_back(p);
      end
    end
  endtask

  // per-clock comparison of the RAM port against the reference op list
  always @(negedge clk) begin
    if (!rst && (mem_we || mem_re)) begin
      if (q_we.size() == 0) begin
        chk("R6/R7 unexpected RAM access", {mem_we, mem_re}, 2'b00);
      end else begin
        bit we_e; int a_e; logic [63:0] d_e; int p_e; string tag;
        we_e = q_we.pop_front(); a_e = q_addr.pop_front();
        d_e = q_data.pop_front(); p_e = q_pat.pop_front();
        tag = (p_e < 9) ? "R1/R2 op" : (p_e == 9) ? "R1/R3 op" : "R1/R4 op";
        chk(tag, {mem_we, mem_re, mem_addr, (we_e ? mem_wdata : 64'h0)},
                 {we_e, !we_e, AW'(a_e), d_e});
      end
    end
  end

  task automatic run(int lo, int hi, bit poke_mid);
    @(negedge clk);
    start_addr = AW'(lo); end_addr = AW'(hi); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_mid) begin
      repeat (40) @(negedge clk);
      start_addr = AW'(1); end_addr = AW'(3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 reset outputs", {done, fail, mem_we, mem_re, pass_count, fail_count}, '0);
    rst = 1'b0;
    @(negedge clk);

    // fault-free run with a start pulse in the middle (R1..R5, R7 ignore)
    build_ops(4, 20);
    run(4, 20, 1'b1);
    chk("R5 all ops seen in order", q_we.size(), 0);
    chk("R7 done/fail after pass", {done, fail}, 2'b10);
    chk("R8 counters after pass", {pass_count, fail_count}, {CW'(1), CW'(0)});
    repeat (6) @(negedge clk);
    chk("R7 done held", done, 1'b1);

    // stuck-at-one bit 0 at word 7: caught by background pattern 0 (R6)
    stuck_en = 1'b1; stuck_addr = AW'(7); stuck_mask = 64'h1; stuck_val = 64'h1;
    build_ops(4, 20);
    run(4, 20, 1'b0);
    q_we.delete(); q_addr.delete(); q_data.delete(); q_pat.delete();
    chk("R6 fail flag", {done, fail}, 2'b11);
    chk("R6 fail_addr", fail_addr, AW'(7));
    chk("R6 fail_expected", fail_expected, 64'h0);
    chk("R5 fail_actual", fail_actual, 64'h1);
    chk("R8 counters after fail", {pass_count, fail_count}, {CW'(1), CW'(1)});
    repeat (6) @(negedge clk);
    stuck_en = 1'b0;

    // aliasing decoder: writes to 12 also hit 5; only the address test sees it (R3)
    alias_en = 1'b1; alias_lo = AW'(5); alias_hi = AW'(12);
    build_ops(4, 20);
    run(4, 20, 1'b0);
    q_we.delete(); q_addr.delete(); q_data.delete(); q_pat.delete();
    chk("R3 alias fail_addr", fail_addr, AW'(5));
    chk("R3 alias fail_expected", fail_expected, 64'd5);
    chk("R3 alias fail_actual", fail_actual, 64'd12);
    chk("R8 counters after second fail", {pass_count, fail_count}, {CW'(1), CW'(2)});
    alias_en = 1'b0;

    // empty range: passes with no RAM access (R1)
    build_ops(9, 9);
    run(9, 9, 1'b0);
    chk("R1 empty range result", {done, fail}, 2'b10);
    chk("R8 counters after empty", {pass_count, fail_count}, {CW'(2), CW'(2)});

    // single word at top of the address space (R1, R4)
    build_ops(62, 63);
    run(62, 63, 1'b0);
    chk("R4 single word ops seen", q_we.size(), 0);
    chk("R1 single word result", {done, fail, fail_addr}, {2'b10, AW'(0)});
    chk("R8 counters after single", {pass_count, fail_count}, {CW'(3), CW'(2)});

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule